// File: doc/BRIEF.md
# Emulator mode state controller

This block holds the emulator-mode bit of a processor core while it services debug interrupts. A debug handler runs with the bit set. A normal exception may still arrive while that handler runs. When it does, the controller folds the bit into the fault-status code that the core writes into the new exception frame, and it clears the live bit so that the normal handler runs outside emulator mode. On return from exception, the core hands back the fault-status value it popped from the stack. A dedicated code brings emulator mode back and resumes the interrupted debug handler. Any other code on a return taken inside emulator mode ends emulator mode.

Each time emulator mode is entered or resumed, the block drives a processor-status code that marks debug-interrupt entry for one cycle. When a return leaves emulator mode, the block raises a breakpoint-inhibit signal. That signal holds off further hardware breakpoints until the next instruction has retired. Separately, the block samples normal interrupt requests once per retired instruction, in every mode. All outputs are registered and react one clock after the strobe that causes them.

Top module: `emu_mode_ctrl`

## Requirements
- R1: During and straight after synchronous reset, `emu_o`=0, `frame_fs_o`=4'b0000, `pst_o`=4'h0, `bkpt_inhibit_o`=0 and `irq_sample_o`=0.
- R2: An accepted debug-entry strobe sets `emu_o` on the next cycle and drives `pst_o`=4'hD for exactly that cycle, after which `pst_o` falls back to 4'h0 unless a new entry occurs.
- R3: An accepted exception strobe while `emu_o`=1 clears `emu_o` and loads `frame_fs_o` with 4'b0010 on the next cycle.
- R4: An accepted exception strobe while `emu_o`=0 loads `frame_fs_o` with 4'b0000 and leaves `emu_o` at 0.
- R5: An accepted return strobe with reloaded fault status 4'b0010 sets `emu_o` and drives `pst_o`=4'hD for one cycle.
- R6: An accepted return strobe with any reloaded code other than 4'b0010 while `emu_o`=1 clears `emu_o` and raises `bkpt_inhibit_o` on the next cycle.
- R7: `bkpt_inhibit_o` stays high until a retire strobe is sampled in a cycle later than the exiting return, and it drops on the cycle after that strobe. A retire strobe in the same cycle as the exiting return does not count.
- R8: A return strobe with a non-0010 code while `emu_o`=0 leaves `emu_o` at 0 and does not raise `bkpt_inhibit_o`.
- R9: When strobes coincide, debug entry wins over exception entry, and exception entry wins over return. The losing strobes have no effect on `emu_o`, `frame_fs_o` or `pst_o`.
- R10: `irq_sample_o` is 1 on the cycle after a cycle in which both the retire strobe and the interrupt request were high, regardless of `emu_o`, and is 0 otherwise.
- R11: `frame_fs_o` holds its value in every cycle without an accepted exception strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_entry_i | input | 1 | Debug-interrupt entry strobe |
| exc_entry_i | input | 1 | Normal exception entry strobe |
| rte_i | input | 1 | Return-from-exception strobe |
| rte_fs_i | input | FS_W | Fault status reloaded from the stack on return |
| retire_i | input | 1 | Instruction-retire strobe |
| irq_req_i | input | 1 | Normal interrupt request level |
| emu_o | output | 1 | Emulator-mode flag |
| frame_fs_o | output | FS_W | Fault status for the newest exception frame |
| pst_o | output | PST_W | Processor-status code |
| bkpt_inhibit_o | output | 1 | Hardware breakpoint inhibit |
| irq_sample_o | output | 1 | Interrupt request sampled at retire |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the exiting return and the retire strobe. When they coincide, the retire must not count, because the inhibit window has to outlast the return and end only at a later retire. The bench drives both strobes in one cycle and then checks that the inhibit is still high. It then issues an idle cycle and a separate retire and checks that the inhibit falls after that retire.

The second pair is an exception that collides with a restoring return or with a debug entry. The priority order decides these cases. The bench provokes them directly and also through a seeded random stream with dense strobes. In every cycle it compares each output with a reference model built from the requirements.

// File: rtl/emu_pkg.sv
package emu_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_DBG,
    EV_EXC,
    EV_RTE_RESTORE,
    EV_RTE_EXIT,
    EV_RTE_PLAIN
  } emu_evt_e;

endpackage

// File: rtl/emu_evt_arb.sv
module emu_evt_arb
  import emu_pkg::*;
#(
  parameter int FS_W = 4,
  parameter logic [FS_W-1:0] FS_EMU = 4'b0010
) (
  input  logic            dbg_entry_i,
  input  logic            exc_entry_i,
  input  logic            rte_i,
  input  logic [FS_W-1:0] rte_fs_i,
  input  logic            emu_q,
  output emu_evt_e        evt_o
);

  logic fs_match;

  assign fs_match = (rte_fs_i == FS_EMU);

  always_comb begin
    evt_o = EV_NONE;
    if (dbg_entry_i) begin
      evt_o = EV_DBG;
    end else if (exc_entry_i) begin
      evt_o = EV_EXC;
    end else if (rte_i) begin
      if (fs_match)   evt_o = EV_RTE_RESTORE;
      else if (emu_q) evt_o = EV_RTE_EXIT;
      else            evt_o = EV_RTE_PLAIN;
    end
  end

endmodule

// File: rtl/emu_state.sv
module emu_state
  import emu_pkg::*;
#(
  parameter int FS_W = 4,
  parameter int PST_W = 4,
  parameter logic [FS_W-1:0]  FS_EMU   = 4'b0010,
  parameter logic [FS_W-1:0]  FS_NORM  = 4'b0000,
  parameter logic [PST_W-1:0] PST_DBG  = 4'hD,
  parameter logic [PST_W-1:0] PST_IDLE = 4'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  emu_evt_e         evt_i,
  output logic             emu_q,
  output logic [FS_W-1:0]  frame_fs_q,
  output logic [PST_W-1:0] pst_q
);

  logic             emu_d;
  logic [FS_W-1:0]  fs_d;
  logic [PST_W-1:0] pst_d;

  always_comb begin
    emu_d = emu_q;
    fs_d  = frame_fs_q;
    pst_d = PST_IDLE;
    unique case (evt_i)
      EV_DBG: begin
        emu_d = 1'b1;
        pst_d = PST_DBG;
      end
      EV_EXC: begin
        fs_d  = emu_q ? FS_EMU : FS_NORM;
        emu_d = 1'b0;
      end
      EV_RTE_RESTORE: begin
        emu_d = 1'b1;
        pst_d = PST_DBG;
      end
      EV_RTE_EXIT:  emu_d = 1'b0;
      EV_RTE_PLAIN: emu_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_q      <= 1'b0;
      frame_fs_q <= FS_NORM;
      pst_q      <= PST_IDLE;
    end else begin
      emu_q      <= emu_d;
      frame_fs_q <= fs_d;
      pst_q      <= pst_d;
    end
  end

endmodule

// File: rtl/emu_bkpt_inhibit.sv
module emu_bkpt_inhibit
  import emu_pkg::*;
#(
  parameter int INHIBIT_RETIRES = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  emu_evt_e evt_i,
  input  logic     retire_i,
  output logic     inhibit_q
);

  localparam int CNT_W = (INHIBIT_RETIRES > 1) ? $clog2(INHIBIT_RETIRES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INHIBIT_RETIRES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit_q <= 1'b0;
      cnt_q     <= '0;
    end else if (evt_i == EV_RTE_EXIT) begin
      inhibit_q <= 1'b1;
      cnt_q     <= '0;
    end else if (inhibit_q && retire_i) begin
      if (cnt_q == CNT_LAST) begin
        inhibit_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/emu_irq_sampler.sv
module emu_irq_sampler (
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  input  logic irq_req_i,
  output logic sample_q
);

  always_ff @(posedge clk) begin
    if (rst) sample_q <= 1'b0;
    else     sample_q <= retire_i & irq_req_i;
  end

endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
  import emu_pkg::*;
#(
  parameter int FS_W = 4,
  parameter int PST_W = 4,
  parameter logic [FS_W-1:0]  FS_EMU   = 4'b0010,
  parameter logic [FS_W-1:0]  FS_NORM  = 4'b0000,
  parameter logic [PST_W-1:0] PST_DBG  = 4'hD,
  parameter logic [PST_W-1:0] PST_IDLE = 4'h0,
  parameter int INHIBIT_RETIRES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_entry_i,
  input  logic             exc_entry_i,
  input  logic             rte_i,
  input  logic [FS_W-1:0]  rte_fs_i,
  input  logic             retire_i,
  input  logic             irq_req_i,
  output logic             emu_o,
  output logic [FS_W-1:0]  frame_fs_o,
  output logic [PST_W-1:0] pst_o,
  output logic             bkpt_inhibit_o,
  output logic             irq_sample_o
);

  emu_evt_e evt;

  emu_evt_arb #(.FS_W(FS_W), .FS_EMU(FS_EMU)) u_arb (
    .dbg_entry_i (dbg_entry_i),
    .exc_entry_i (exc_entry_i),
    .rte_i       (rte_i),
    .rte_fs_i    (rte_fs_i),
    .emu_q       (emu_o),
    .evt_o       (evt)
  );

  emu_state #(
    .FS_W(FS_W), .PST_W(PST_W), .FS_EMU(FS_EMU), .FS_NORM(FS_NORM),
    .PST_DBG(PST_DBG), .PST_IDLE(PST_IDLE)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .emu_q      (emu_o),
    .frame_fs_q (frame_fs_o),
    .pst_q      (pst_o)
  );

  emu_bkpt_inhibit #(.INHIBIT_RETIRES(INHIBIT_RETIRES)) u_inh (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .retire_i  (retire_i),
    .inhibit_q (bkpt_inhibit_o)
  );

  emu_irq_sampler u_irq (
    .clk       (clk),
    .rst       (rst),
    .retire_i  (retire_i),
    .irq_req_i (irq_req_i),
    .sample_q  (irq_sample_o)
  );

endmodule

// File: rtl/emu_mode_ctrl_chk.sv
module emu_mode_ctrl_chk #(
  parameter int FS_W = 4,
  parameter int PST_W = 4,
  parameter logic [FS_W-1:0]  FS_EMU   = 4'b0010,
  parameter logic [FS_W-1:0]  FS_NORM  = 4'b0000,
  parameter logic [PST_W-1:0] PST_DBG  = 4'hD,
  parameter logic [PST_W-1:0] PST_IDLE = 4'h0
) (
  input logic             clk,
  input logic             rst,
  input logic             dbg_entry_i,
  input logic             exc_entry_i,
  input logic             rte_i,
  input logic [FS_W-1:0]  rte_fs_i,
  input logic             retire_i,
  input logic             irq_req_i,
  input logic             emu_o,
  input logic [FS_W-1:0]  frame_fs_o,
  input logic [PST_W-1:0] pst_o,
  input logic             bkpt_inhibit_o,
  input logic             irq_sample_o
);

  p_dbg_sets_r2: assert property (@(posedge clk) disable iff (rst)
    dbg_entry_i |=> (emu_o && pst_o == PST_DBG));

  p_pst_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (pst_o == PST_DBG && !dbg_entry_i && !rte_i) |=> (pst_o == PST_IDLE));

  p_exc_in_emu_r3: assert property (@(posedge clk) disable iff (rst)
    (exc_entry_i && !dbg_entry_i && emu_o) |=> (!emu_o && frame_fs_o == FS_EMU));

  p_exc_out_r4: assert property (@(posedge clk) disable iff (rst)
    (exc_entry_i && !dbg_entry_i && !emu_o) |=> (!emu_o && frame_fs_o == FS_NORM));

  p_rte_restore_r5: assert property (@(posedge clk) disable iff (rst)
    (rte_i && !dbg_entry_i && !exc_entry_i && rte_fs_i == FS_EMU) |=> (emu_o && pst_o == PST_DBG));

  p_rte_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (rte_i && !dbg_entry_i && !exc_entry_i && emu_o && rte_fs_i != FS_EMU) |=> (!emu_o && bkpt_inhibit_o));

  p_rte_plain_r8: assert property (@(posedge clk) disable iff (rst)
    (rte_i && !dbg_entry_i && !exc_entry_i && !emu_o && !bkpt_inhibit_o && rte_fs_i != FS_EMU)
      |=> (!emu_o && !bkpt_inhibit_o));

  p_irq_sample_r10: assert property (@(posedge clk) disable iff (rst)
    (retire_i && irq_req_i) |=> irq_sample_o);

  p_fs_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!exc_entry_i || dbg_entry_i) |=> $stable(frame_fs_o));

endmodule

bind emu_mode_ctrl emu_mode_ctrl_chk #(
  .FS_W(FS_W), .PST_W(PST_W), .FS_EMU(FS_EMU), .FS_NORM(FS_NORM),
  .PST_DBG(PST_DBG), .PST_IDLE(PST_IDLE)
) u_chk (.*);

// File: tb/emu_mode_ctrl_tb.sv
`timescale 1ns/1ps
module emu_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbg = 1'b0, exc = 1'b0, rte = 1'b0, ret = 1'b0, irq = 1'b0;
  logic [3:0] fs_in = 4'h0;
  logic       emu_o, inh_o, irqs_o;
  logic [3:0] fs_o, pst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       m_emu, m_inh, m_irq;
  logic [3:0] m_fs, m_pst;

  always #2.5 clk = ~clk;

  emu_mode_ctrl u_dut (
    .clk(clk), .rst(rst),
    .dbg_entry_i(dbg), .exc_entry_i(exc), .rte_i(rte), .rte_fs_i(fs_in),
    .retire_i(ret), .irq_req_i(irq),
    .emu_o(emu_o), .frame_fs_o(fs_o), .pst_o(pst_o),
    .bkpt_inhibit_o(inh_o), .irq_sample_o(irqs_o)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_emu = 1'b0; m_inh = 1'b0; m_irq = 1'b0; m_fs = 4'h0; m_pst = 4'h0;
  endtask

  // Next-state reference built from the requirements.
  task automatic model_step(input logic d, input logic e, input logic r,
                            input logic [3:0] f, input logic t, input logic q);
    logic exit_now;
    exit_now = !d && !e && r && m_emu && (f != 4'b0010);
    m_irq = t && q;
    if (exit_now) m_inh = 1'b1;
    else if (m_inh && t) m_inh = 1'b0;
    m_pst = 4'h0;
    if (d) begin
      m_emu = 1'b1; m_pst = 4'hD;
    end else if (e) begin
      m_fs = m_emu ? 4'b0010 : 4'b0000;
      m_emu = 1'b0;
    end else if (r) begin
      if (f == 4'b0010) begin
        m_emu = 1'b1; m_pst = 4'hD;
      end else begin
        m_emu = 1'b0;
      end
    end
  endtask

  task automatic cyc(input logic d, input logic e, input logic r, input logic [3:0] f,
                     input logic t, input logic q, input string tag);
    dbg = d; exc = e; rte = r; fs_in = f; ret = t; irq = q;
    model_step(d, e, r, f, t, q);
    @(posedge clk);
    @(negedge clk);
    check(tag, {3'b0, emu_o},  {3'b0, m_emu}, "emu");
    check(tag, fs_o,           m_fs,          "frame_fs");
    check(tag, pst_o,          m_pst,         "pst");
    check(tag, {3'b0, inh_o},  {3'b0, m_inh}, "inhibit");
    check(tag, {3'b0, irqs_o}, {3'b0, m_irq}, "irq_sample");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1", {3'b0, emu_o}, 4'h0, "emu");
    check("R1", fs_o, 4'h0, "frame_fs");
    check("R1", pst_o, 4'h0, "pst");
    check("R1", {3'b0, inh_o}, 4'h0, "inhibit");
    rst = 1'b0;
    cyc(0,0,0,4'h0,0,0, "R1");
    cyc(1,0,0,4'h0,0,0, "R2");      // debug entry
    cyc(0,0,0,4'h0,0,0, "R2");      // pulse ends
    cyc(0,1,0,4'h0,0,0, "R3");      // exception inside emulator mode
    cyc(0,0,0,4'h0,0,0, "R11");     // frame fs held
    cyc(0,0,1,4'b0010,0,0, "R5");   // restoring return
    cyc(0,0,1,4'h0,1,0, "R6");      // exiting return with retire in same cycle
    cyc(0,0,0,4'h0,0,0, "R7");      // inhibit still high
    cyc(0,0,0,4'h0,1,0, "R7");      // retire drops inhibit
    cyc(0,1,0,4'h0,0,0, "R4");      // exception outside emulator mode
    cyc(0,0,1,4'h5,0,0, "R8");      // plain return, no inhibit
    cyc(1,1,0,4'h0,0,0, "R9");      // debug beats exception
    cyc(0,1,1,4'b0010,0,0, "R9");   // exception beats restoring return
    cyc(1,0,0,4'h0,0,0, "R2");
    cyc(0,0,0,4'h0,1,1, "R10");     // sampling in emulator mode
    cyc(0,0,0,4'h0,1,0, "R10");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] f;
      f = ($urandom_range(0, 2) == 0) ? 4'b0010 : 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 9) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 3) == 0, f,
          $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, "R9");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule